// File: doc/BRIEF.md
# SPI Configuration Session Sequencer

This block is the SPI master side of a configuration loader for a programmable logic device that accepts its image over a serial slave port. A single start strobe runs a whole session. The block opens the device's configuration access and reads back a four-byte result word, which must be zero. It then switches the device into programming mode and pushes the image as fixed frames of sixteen bytes. Each frame goes out behind its own frame opcode. At the end the block closes configuration access, holds off for a programmable delay, and releases the device.

The image arrives as a byte stream with a valid/ready handshake. Its total length in bytes is presented with the start strobe. Before every chip-select assertion the sequencer asks an external status-poll block whether the target is idle. Before the result read it asks whether the target is also ready. A failed poll, a non-zero result word, or a length that is not a whole number of frames ends the session with a sticky error flag. A program-mode flag tracks whether the target has been left in programming mode.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, and busy, done, err, prog_mode, poll_req and data_ready are all 0.
- R2: A start whose total_bytes has any of bits [3:0] set raises err on the next cycle and leaves busy at 0, with no chip-select activity.
- R3: A good session sends these chip-select transactions in order, each byte MSB first: {0x0B}; {0x01, 0x00, 0x00, 0x00, 0x00}; {0xAE, 0x01}; one {0xEE + 16 stream bytes} per frame (frames = total_bytes/16); {0x0C}; {0x23}.
- R4: The SPI port runs in mode 0: sclk is 0 whenever cs_n is 1, MOSI is stable at each rising sclk edge, and MISO is sampled on the rising edge.
- R5: cs_n falls only in the cycle after the poll block answers poll_ack=1 with poll_fail=0.
- R6: poll_want_ready is 1 only during the poll that precedes the 0x01 result-read transaction.
- R7: If any of the four result bytes clocked in after the 0x01 opcode is non-zero, the session stops after that transaction with err=1, cs_n=1 and prog_mode=0.
- R8: A poll answered with poll_fail=1 aborts the session with cs_n=1 and err=1; err stays set until the next start, which clears it one cycle later.
- R9: Between the end of the 0x0C transaction and the start of the 0x23 transaction, cs_n stays high for more than HOLD_CYCLES clock cycles.
- R10: prog_mode rises only after the 0xAE 0x01 transaction completes, and falls when the 0x23 transaction completes, together with done rising.
- R11: data_ready is 1 only while a frame transaction is open and waiting for its next payload byte. Exactly 16 stream bytes are consumed per frame, in stream order, and a gap in data_valid stalls the frame without losing bytes.
- R12: A start pulse while busy is 1 is ignored and leaves the transaction sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a session when idle |
| total_bytes | input | LEN_W | Image length in bytes, sampled at start |
| data_in | input | 8 | Image stream byte |
| data_valid | input | 1 | data_in holds a byte |
| data_ready | output | 1 | Sequencer takes data_in this cycle |
| poll_req | output | 1 | Asks the poll block for a target status verdict |
| poll_want_ready | output | 1 | The verdict must also require the ready bit |
| poll_ack | input | 1 | Poll block verdict strobe |
| poll_fail | input | 1 | Verdict is a timeout or error (valid with poll_ack) |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to target |
| cs_n | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data from target |
| busy | output | 1 | A session is in progress |
| done | output | 1 | Last session completed successfully |
| err | output | 1 | Last session failed (sticky until next start) |
| prog_mode | output | 1 | Target has been put in programming mode and not yet released |

## Verification
The bench runs full sessions with one and with several frames. One runs with a continuous stream and one with a stream that drops valid every fourth cycle. Comparing each against the same expected transaction list shows that backpressure changes timing only, never content. A long session also carries a stray start pulse to show that it cannot restart the sequence. Failure paths use three patterns: a length that is not a frame multiple, a result word with a single set bit in its third byte, and a poll failure injected at the second frame. Each has a distinct expected truncation of the transaction list and of prog_mode.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_POLL, PH_LOAD, PH_SHIFT, PH_WAIT
    } phase_e;

    typedef enum logic [2:0] {
        SG_ENABLE, SG_RESULT, SG_PROGRAM, SG_FRAME, SG_DISABLE, SG_RELEASE
    } stage_e;

    localparam logic [7:0] OP_ENABLE   = 8'h0B;
    localparam logic [7:0] OP_DISABLE  = 8'h0C;
    localparam logic [7:0] OP_READ     = 8'h01;
    localparam logic [7:0] OP_MODE     = 8'hAE;
    localparam logic [7:0] OP_MODE_ARG = 8'h01;
    localparam logic [7:0] OP_FRAME    = 8'hEE;
    localparam logic [7:0] OP_RELEASE  = 8'h23;

    localparam int FRAME_BYTES  = 16;
    localparam int RESULT_BYTES = 4;

    // index of the final byte of each transaction
    function automatic logic [4:0] stage_last(stage_e s);
        case (s)
            SG_RESULT:  return 5'(RESULT_BYTES);
            SG_PROGRAM: return 5'd1;
            SG_FRAME:   return 5'(FRAME_BYTES);
            default:    return 5'd0;
        endcase
    endfunction

    function automatic logic [7:0] stage_opcode(stage_e s);
        case (s)
            SG_ENABLE:  return OP_ENABLE;
            SG_RESULT:  return OP_READ;
            SG_PROGRAM: return OP_MODE;
            SG_FRAME:   return OP_FRAME;
            SG_DISABLE: return OP_DISABLE;
            default:    return OP_RELEASE;
        endcase
    endfunction

endpackage

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       tx_done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic          act;
        logic          sclk;
        logic [3:0]    nbit;
        logic [DW-1:0] div;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d       = q;
        tx_done = 1'b0;
        if (!q.act) begin
            if (go) begin
                d.act  = 1'b1;
                d.tx   = tx_byte;
                d.nbit = '0;
                d.div  = '0;
                d.sclk = 1'b0;
            end
        end else if (q.div == DW'(HALF_DIV - 1)) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
                d.nbit = q.nbit + 4'd1;
            end else begin
                d.sclk = 1'b0;
                d.tx   = {q.tx[6:0], 1'b0};
                if (q.nbit == 4'd8) begin
                    d.act   = 1'b0;
                    tx_done = 1'b1;
                end
            end
        end else begin
            d.div = q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sclk;
    assign mosi    = q.tx[7];
    assign rx_byte = q.rx;

    // R4
    sclk_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.act |-> !sclk);

    // R4
    mosi_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

endmodule

// File: rtl/cfg_hold_timer.sv
module cfg_hold_timer #(
    parameter int HOLD_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          run;
        logic          exp;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (kick) begin
            d.run = 1'b1;
            d.exp = 1'b0;
            d.cnt = '0;
        end else if (q.run) begin
            if (q.cnt == CW'(HOLD_CYCLES - 1)) begin
                d.run = 1'b0;
                d.exp = 1'b1;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = q.exp;

    // R9
    no_early_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !expired);

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int LEN_W       = 20,
    parameter int SCK_DIV     = 2,
    parameter int CLK_HZ      = 50_000_000,
    parameter int HOLD_CYCLES = CLK_HZ / 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_bytes,
    input  logic [7:0]       data_in,
    input  logic             data_valid,
    output logic             data_ready,
    output logic             poll_req,
    output logic             poll_want_ready,
    input  logic             poll_ack,
    input  logic             poll_fail,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             prog_mode
);
    localparam int FW = LEN_W - $clog2(FRAME_BYTES);

    typedef struct packed {
        phase_e        phase;
        stage_e        stage;
        logic [4:0]    idx;
        logic [FW-1:0] frames;
        logic [7:0]    res;
        logic          cs_n;
        logic          done;
        logic          err;
        logic          prog;
    } seq_t;

    seq_t q, d;

    logic       sh_go, sh_done, tmr_kick, tmr_exp, byte_avail;
    logic [7:0] sh_byte, sh_rx, res_new;

    cfg_spi_shifter #(.HALF_DIV(SCK_DIV)) i_shifter (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_byte),
        .tx_done(sh_done), .rx_byte(sh_rx), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    cfg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
        .clk(clk), .rst_n(rst_n), .kick(tmr_kick), .expired(tmr_exp)
    );

    // byte to put on the wire for the current position
    always_comb begin
        byte_avail = 1'b1;
        if (q.idx == '0) begin
            sh_byte = stage_opcode(q.stage);
        end else begin
            case (q.stage)
                SG_PROGRAM: sh_byte = OP_MODE_ARG;
                SG_FRAME: begin
                    sh_byte    = data_in;
                    byte_avail = data_valid;
                end
                default:    sh_byte = 8'h00;
            endcase
        end
    end

    assign res_new = q.res | ((q.stage == SG_RESULT && q.idx != '0) ? sh_rx : 8'h00);

    always_comb begin
        d        = q;
        sh_go    = 1'b0;
        tmr_kick = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    if (total_bytes[3:0] != 4'd0) begin
                        d.err = 1'b1;
                    end else begin
                        d.frames = total_bytes[LEN_W-1:4];
                        d.stage  = SG_ENABLE;
                        d.phase  = PH_POLL;
                    end
                end
            end
            PH_POLL: begin
                if (poll_ack) begin
                    if (poll_fail) begin
                        d.err   = 1'b1;
                        d.phase = PH_IDLE;
                    end else begin
                        d.cs_n  = 1'b0;
                        d.idx   = '0;
                        d.res   = '0;
                        d.phase = PH_LOAD;
                    end
                end
            end
            PH_LOAD: begin
                if (byte_avail) begin
                    sh_go   = 1'b1;
                    d.phase = PH_SHIFT;
                end
            end
            PH_SHIFT: begin
                if (sh_done) begin
                    d.res = res_new;
                    if (q.idx != stage_last(q.stage)) begin
                        d.idx   = q.idx + 5'd1;
                        d.phase = PH_LOAD;
                    end else begin
                        d.cs_n  = 1'b1;
                        d.phase = PH_POLL;
                        case (q.stage)
                            SG_ENABLE: d.stage = SG_RESULT;
                            SG_RESULT: begin
                                if (res_new != 8'h00) begin
                                    d.err   = 1'b1;
                                    d.phase = PH_IDLE;
                                end else begin
                                    d.stage = SG_PROGRAM;
                                end
                            end
                            SG_PROGRAM: begin
                                d.prog  = 1'b1;
                                d.stage = (q.frames == '0) ? SG_DISABLE : SG_FRAME;
                            end
                            SG_FRAME: begin
                                d.frames = q.frames - FW'(1);
                                if (q.frames == FW'(1)) d.stage = SG_DISABLE;
                            end
                            SG_DISABLE: begin
                                tmr_kick = 1'b1;
                                d.phase  = PH_WAIT;
                            end
                            default: begin
                                d.prog  = 1'b0;
                                d.done  = 1'b1;
                                d.phase = PH_IDLE;
                            end
                        endcase
                    end
                end
            end
            PH_WAIT: begin
                if (tmr_exp) begin
                    d.stage = SG_RELEASE;
                    d.phase = PH_POLL;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_n  <= 1'b1;
            q.phase <= PH_IDLE;
            q.stage <= SG_ENABLE;
        end else begin
            q <= d;
        end
    end

    assign cs_n            = q.cs_n;
    assign busy            = (q.phase != PH_IDLE);
    assign done            = q.done;
    assign err             = q.err;
    assign prog_mode       = q.prog;
    assign poll_req        = (q.phase == PH_POLL);
    assign poll_want_ready = (q.phase == PH_POLL) && (q.stage == SG_RESULT);
    assign data_ready      = (q.phase == PH_LOAD) && (q.stage == SG_FRAME) && (q.idx != '0);

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5
    cs_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(poll_ack && !poll_fail));

    // R8
    err_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !sclk));

    // R10
    done_clears_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !prog_mode);

    // R11
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> !cs_n);

endmodule

// File: tb/test_cfg_load_seq.sv
module test_cfg_load_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;
    localparam int HOLD       = 20;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [LEN_W-1:0] total_bytes = '0;
    logic [7:0] data_in = '0;
    logic data_valid = 1'b0, data_ready;
    logic poll_req, poll_want_ready, poll_ack = 1'b0, poll_fail = 1'b0;
    logic sclk, mosi, cs_n, miso, busy, done, err, prog_mode;

    cfg_load_seq #(.LEN_W(LEN_W), .SCK_DIV(2), .HOLD_CYCLES(HOLD)) i_cfg_load_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .total_bytes(total_bytes),
        .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready),
        .poll_req(poll_req), .poll_want_ready(poll_want_ready), .poll_ack(poll_ack),
        .poll_fail(poll_fail), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
        .busy(busy), .done(done), .err(err), .prog_mode(prog_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int mon_q[$], exp_q[$];
    bit want_q[$];
    int mbits = 0, rbit = 0, sidx = 0, poll_n = 0, pdly = 1, fail_at = -1;
    int dis_cyc = -1, last_gap = 0;
    logic [7:0] mbyte = 8'h00, last_byte = 8'h00;
    logic [39:0] resp;
    logic [31:0] rd_result = 32'h0;
    bit gaps = 0, cs_prev = 1'b1, prog_prev = 1'b0;

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // target model: result word follows the opcode byte, MSB first
    assign resp = {8'h00, rd_result};
    assign miso = (rbit < 40) ? resp[39 - rbit] : 1'b0;

    always @(negedge cs_n) begin mbits = 0; rbit = 0; end
    always @(posedge cs_n) if (rst_n) mon_q.push_back(-1);
    always @(posedge sclk) if (!cs_n) begin
        mbyte = {mbyte[6:0], mosi};
        mbits++;
        rbit++;
        if (mbits == 8) begin
            mon_q.push_back(int'(mbyte));
            last_byte = mbyte;
            mbits = 0;
        end
    end

    // stream handshake as the design sees it at the edge
    always @(posedge clk) if (data_valid && data_ready) sidx++;

    // poll responder, stream driver, per-cycle checks
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (!rst_n) begin
            poll_ack = 1'b0;
        end else begin
            if (poll_ack) poll_ack = 1'b0;
            else if (poll_req) begin
                if (pdly == 0) begin
                    poll_ack  = 1'b1;
                    poll_fail = (poll_n == fail_at);
                    want_q.push_back(poll_want_ready);
                    poll_n++;
                    pdly = poll_n % 3;
                end else pdly--;
            end
            // R4: clock idles low outside a transaction
            chk(!(cs_n && sclk), "R4", sclk, 0);
            // R11: no stream request outside an open transaction
            chk(!(data_ready && cs_n), "R11", data_ready, 0);
            // R6: ready qualifier only with a poll request
            chk(!(poll_want_ready && !poll_req), "R6", poll_want_ready, 0);
            if (!cs_prev && cs_n && last_byte == 8'h0C) dis_cyc = cyc;
            if (cs_prev && !cs_n && dis_cyc >= 0) begin
                last_gap = cyc - dis_cyc;
                dis_cyc = -1;
            end
            if (prog_mode && !prog_prev)
                chk(last_byte == 8'h01 && cs_n, "R10", last_byte, 1);
            cs_prev   = cs_n;
            prog_prev = prog_mode;
        end
        data_valid = gaps ? ((cyc % 4) != 1) : 1'b1;
        data_in    = pat(sidx);
    end

    task automatic add_frame(int base, int f);
        exp_q.push_back(8'hEE);
        for (int j = 0; j < 16; j++) exp_q.push_back(int'(pat(base + 16 * f + j)));
        exp_q.push_back(-1);
    endtask

    // stop: 0 full, 1 after result read, 2 after first frame
    task automatic build(int nfrm, int stop, int base);
        exp_q.delete();
        exp_q.push_back(8'h0B); exp_q.push_back(-1);
        exp_q.push_back(8'h01);
        for (int j = 0; j < 4; j++) exp_q.push_back(0);
        exp_q.push_back(-1);
        if (stop == 1) return;
        exp_q.push_back(8'hAE); exp_q.push_back(8'h01); exp_q.push_back(-1);
        if (stop == 2) begin add_frame(base, 0); return; end
        for (int f = 0; f < nfrm; f++) add_frame(base, f);
        exp_q.push_back(8'h0C); exp_q.push_back(-1);
        exp_q.push_back(8'h23); exp_q.push_back(-1);
    endtask

    task automatic compare(string req);
        int n;
        chk(mon_q.size() == exp_q.size(), req, mon_q.size(), exp_q.size());
        n = (mon_q.size() < exp_q.size()) ? mon_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) chk(mon_q[i] == exp_q[i], req, mon_q[i], exp_q[i]);
    endtask

    task automatic check_polls(string req);
        for (int i = 0; i < want_q.size(); i++)
            chk(want_q[i] == (i == 1), req, want_q[i], (i == 1));
    endtask

    task automatic run(int lenb, bit gaps_i, bit extra);
        gaps = gaps_i;
        poll_n = 0;
        pdly = 1;
        mon_q.delete();
        want_q.delete();
        @(negedge clk);
        total_bytes = LEN_W'(lenb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30000 && (busy || i < 2); i++) begin
            @(negedge clk);
            start = (extra && i == 300);
        end
        start = 1'b0;
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cs_n == 1 && sclk == 0, "R1", {cs_n, sclk}, 2);
        chk({busy, done, err, prog_mode, poll_req, data_ready} == 6'b0, "R1",
            {busy, done, err, prog_mode, poll_req, data_ready}, 0);

        // R2: length not a frame multiple
        mon_q.delete();
        @(negedge clk); total_bytes = LEN_W'(40); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(err == 1 && busy == 0, "R2", {err, busy}, 2);
        repeat (5) @(negedge clk);
        chk(mon_q.size() == 0 && cs_n, "R2", mon_q.size(), 0);

        // R3 R9 R10 R11: two frames, continuous stream
        base = sidx;
        run(32, 0, 0);
        build(2, 0, base);
        compare("R3");
        check_polls("R6");
        chk(done == 1 && err == 0 && prog_mode == 0, "R10", {done, err, prog_mode}, 4);
        chk(last_gap > HOLD, "R9", last_gap, HOLD + 1);
        chk(sidx - base == 32, "R11", sidx - base, 32);

        // R11 R12: three frames, gappy stream, stray start mid-session
        base = sidx;
        run(48, 1, 1);
        build(3, 0, base);
        compare("R12");
        chk(sidx - base == 48, "R11", sidx - base, 48);
        chk(done == 1 && err == 0, "R12", {done, err}, 2);

        // R7: non-zero result word
        rd_result = 32'h0000_0100;
        base = sidx;
        run(32, 0, 0);
        rd_result = 32'h0;
        build(2, 1, base);
        compare("R7");
        chk(err == 1 && cs_n == 1 && prog_mode == 0 && done == 0, "R7",
            {err, cs_n, prog_mode, done}, 12);
        chk(sidx == base, "R7", sidx - base, 0);

        // R8: poll failure at the second frame poll
        fail_at = 4;
        base = sidx;
        run(48, 0, 0);
        fail_at = -1;
        build(3, 2, base);
        compare("R8");
        chk(err == 1 && cs_n == 1 && prog_mode == 1, "R8", {err, cs_n, prog_mode}, 7);
        repeat (10) @(negedge clk);
        chk(err == 1 && busy == 0, "R8", {err, busy}, 2);
        @(negedge clk); total_bytes = LEN_W'(16); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(err == 0 && busy == 1, "R8", {err, busy}, 1);
        for (int i = 0; i < 30000 && busy; i++) @(negedge clk);
        chk(done == 1 && err == 0 && prog_mode == 0, "R10", {done, err, prog_mode}, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule